// File: doc/BRIEF.md
# Debug Mailbox Register with Dirty Flag

This block is a one-byte message slot that a running program uses to hand data to an external debugger. The processor stores a byte through its I/O bus write port, and a hardware flag marks the slot as holding unread data. The debugger polls the flag on its own status pin and reads the byte through a side port made of a read strobe and a data bus. That read clears the flag. When the processor reads the slot back, bit 7 carries the flag in place of the stored top data bit.

The slot can sit at the same I/O address as an ordinary read/write register. In that aliased layout, processor accesses reach the slot only while both the debug fuse input and the debugger grant input are high. Otherwise the same address reaches the ordinary register. When the two addresses differ, the slot is always reachable at its own address.

Flow control: the debugger side acts as a stream. The flag is its valid and the read strobe is its ready. The processor side is never back-pressured. A new write overwrites a byte the debugger has not yet read, and the flag stays set.

Top module: `dbgmb_top`

## Requirements
- R1: A processor write that reaches the slot stores all 8 bits of `cpu_wdata` and sets the flag. Both changes appear after the next rising clock edge.
- R2: A processor read that reaches the slot returns, in the same cycle on `cpu_rdata`, the flag in bit 7 and stored bits 6..0 in bits 6..0.
- R3: `dbg_data` always presents all 8 stored bits. A debugger read (`dbg_rd` high at a clock edge) clears the flag after that edge, unless R6 applies.
- R4: With the addresses aliased (the default), an access at the shared address reaches the slot only when `dbg_fuse` and `dbg_grant` are both 1. Otherwise both reads and writes reach the ordinary register.
- R5: A synchronous reset (`rst_n` low at a clock edge) clears the stored byte, the flag and the ordinary register to 0.
- R6: When a processor write to the slot and a debugger read fall in the same cycle, the write wins: the new byte is stored and the flag is 1.
- R7: A processor write that does not reach the slot leaves the stored byte and the flag unchanged. This covers a write blocked by the alias gate and a write to an address with nothing on it.
- R8: A debugger read while the flag is clear leaves the flag clear and the stored byte unchanged.
- R9: Processor reads never change the flag.
- R10: `dbg_status` always equals the flag.
- R11: `cpu_rdata` is 0 when `cpu_rd` is low, or when the read address matches neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | ADDR_W | I/O address of the processor access |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Processor read data, combinational |
| dbg_fuse | input | 1 | Debug fuse input, high when programmed |
| dbg_grant | input | 1 | Debugger has enabled slot access |
| dbg_rd | input | 1 | Debugger read strobe (ready) |
| dbg_data | output | DATA_W | Stored byte as seen by the debugger |
| dbg_status | output | 1 | Unread-data flag (valid) |

## Verification
The bench targets these corner cases:

- **Collision of a write and a debugger read.** A design that let the clear win would drop a fresh byte's flag.
- **Alias gate with only one of its two enables high.** A design using an OR would let the program corrupt the slot while the debugger owns it.
- **Stored byte with bit 7 set.** A design that returned raw data would show a phantom flag to the program.
- **Writes to unmapped or blocked addresses.** A design with loose decode would raise the flag spuriously.
- **Reset in the middle of a run.** A design that skipped the ordinary register or the flag in its reset would leave stale state after reset.

// File: rtl/dbgmb_pkg.sv
package dbgmb_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_MBOX = 2'd1,
    TGT_STD  = 2'd2
  } tgt_e;

  function automatic logic [7:0] fold_flag(input logic flag, input logic [7:0] data);
    return {flag, data[6:0]};
  endfunction

endpackage

// File: rtl/dbgmb_decode.sv
module dbgmb_decode #(
  parameter int unsigned ADDR_W = 6,
  parameter logic [ADDR_W-1:0] MBOX_ADDR = 6'h31,
  parameter logic [ADDR_W-1:0] STD_ADDR = 6'h31
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              fuse,
  input  logic              grant,
  output dbgmb_pkg::tgt_e   tgt
);
  import dbgmb_pkg::*;

  localparam bit SHARED = (MBOX_ADDR == STD_ADDR);

  generate
    if (SHARED) begin : g_alias
      logic gate_open;
      assign gate_open = fuse & grant;
      always_comb begin
        if (addr != MBOX_ADDR) tgt = TGT_NONE;
        else if (gate_open)    tgt = TGT_MBOX;
        else                   tgt = TGT_STD;
      end
    end else begin : g_split
      logic unused_gate;
      assign unused_gate = fuse ^ grant;
      always_comb begin
        if (addr == MBOX_ADDR)     tgt = TGT_MBOX;
        else if (addr == STD_ADDR) tgt = TGT_STD;
        else                       tgt = TGT_NONE;
      end
    end
  endgenerate

endmodule

// File: rtl/dbgmb_slot.sv
module dbgmb_slot #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              take,
  output logic [DATA_W-1:0] data_q,
  output logic              flag_q
);

  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (take)  flag_d = 1'b0;
    if (wr_en) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_en) data_q <= wdata;
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/dbgmb_stdreg.sv
module dbgmb_stdreg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wdata;
  end

endmodule

// File: rtl/dbgmb_top.sv
module dbgmb_top #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] MBOX_ADDR = 6'h31,
  parameter logic [ADDR_W-1:0] STD_ADDR = 6'h31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              dbg_fuse,
  input  logic              dbg_grant,
  input  logic              dbg_rd,
  output logic [DATA_W-1:0] dbg_data,
  output logic              dbg_status
);
  import dbgmb_pkg::*;

  localparam int unsigned LOW_W = DATA_W - 1;

  tgt_e              tgt;
  logic              slot_wr;
  logic              std_wr;
  logic [DATA_W-1:0] slot_q;
  logic              slot_flag;
  logic [DATA_W-1:0] std_q;
  logic [DATA_W-1:0] slot_view;

  dbgmb_decode #(
    .ADDR_W(ADDR_W), .MBOX_ADDR(MBOX_ADDR), .STD_ADDR(STD_ADDR)
  ) u_dec (
    .addr(cpu_addr), .fuse(dbg_fuse), .grant(dbg_grant), .tgt(tgt)
  );

  assign slot_wr = cpu_wr && (tgt == TGT_MBOX);
  assign std_wr  = cpu_wr && (tgt == TGT_STD);

  dbgmb_slot #(.DATA_W(DATA_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .wr_en(slot_wr), .wdata(cpu_wdata),
    .take(dbg_rd), .data_q(slot_q), .flag_q(slot_flag)
  );

  dbgmb_stdreg #(.DATA_W(DATA_W)) u_std (
    .clk(clk), .rst_n(rst_n), .wr_en(std_wr), .wdata(cpu_wdata), .q(std_q)
  );

  assign slot_view = {slot_flag, slot_q[LOW_W-1:0]};

  always_comb begin
    cpu_rdata = '0;
    if (cpu_rd) begin
      unique case (tgt)
        TGT_MBOX: cpu_rdata = slot_view;
        TGT_STD:  cpu_rdata = std_q;
        default:  cpu_rdata = '0;
      endcase
    end
  end

  assign dbg_data   = slot_q;
  assign dbg_status = slot_flag;

endmodule

// File: rtl/dbgmb_checker.sv
module dbgmb_checker #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] MBOX_ADDR = 6'h31,
  parameter logic [ADDR_W-1:0] STD_ADDR = 6'h31
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              dbg_fuse,
  input logic              dbg_grant,
  input logic              dbg_rd,
  input logic [DATA_W-1:0] dbg_data,
  input logic              dbg_status
);

  localparam bit SHARED = (MBOX_ADDR == STD_ADDR);

  logic hits;
  logic mb_wr;
  assign hits  = (cpu_addr == MBOX_ADDR) && (!SHARED || (dbg_fuse && dbg_grant));
  assign mb_wr = cpu_wr && hits;

  AST_WR_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    mb_wr |=> (dbg_status && dbg_data == $past(cpu_wdata))); // R1
  AST_READ_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && hits) |-> (cpu_rdata == {dbg_status, dbg_data[DATA_W-2:0]})); // R2
  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_rd && !mb_wr) |=> !dbg_status); // R3
  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |=> (!dbg_status && dbg_data == '0)); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_wr && dbg_rd) |=> dbg_status); // R6
  AST_NO_STRAY_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !mb_wr |=> $stable(dbg_data)); // R7
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mb_wr && !dbg_rd) |=> $stable(dbg_status)); // R9
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |-> (cpu_rdata == '0)); // R11

endmodule

bind dbgmb_top dbgmb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MBOX_ADDR(MBOX_ADDR), .STD_ADDR(STD_ADDR)
) u_chk (.*);

// File: tb/dbgmb_top_test.sv
module dbgmb_top_test;

  localparam logic [5:0] SHARED_A = 6'h31;
  localparam logic [5:0] EMPTY_A  = 6'h20;
  localparam int NV = 21;

  // {wr, rd, dbgrd, fuse, grant, at_shared, wdata, exp_rdata, exp_flag, exp_data, req}
  localparam logic [34:0] VEC [0:NV-1] = '{
    {1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,8'h35,8'h00,1'b1,8'h35,4'd1},  // R1
    {1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,8'h00,8'hB5,1'b1,8'h35,4'd2},  // R2 R9
    {1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,8'h00,8'h00,1'b0,8'h35,4'd3},  // R3
    {1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,8'h00,8'h35,1'b0,8'h35,4'd2},  // R2
    {1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,8'h00,8'h00,1'b0,8'h35,4'd8},  // R8
    {1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,8'hC3,8'h00,1'b1,8'hC3,4'd6},  // R6
    {1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,8'h00,8'hC3,1'b1,8'hC3,4'd2},  // R2
    {1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,8'h5A,8'h00,1'b1,8'hC3,4'd7},  // R7
    {1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,8'h00,8'h5A,1'b1,8'hC3,4'd4},  // R4
    {1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,8'h11,8'h00,1'b1,8'hC3,4'd7},  // R7
    {1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,8'h00,8'h11,1'b1,8'hC3,4'd4},  // R4
    {1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,8'h00,8'hC3,1'b1,8'hC3,4'd4},  // R4
    {1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,8'h00,8'h00,1'b0,8'hC3,4'd3},  // R3
    {1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,8'h00,8'h43,1'b0,8'hC3,4'd2},  // R2
    {1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,8'h00,8'h00,1'b0,8'hC3,4'd11}, // R11
    {1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,8'hFF,8'h00,1'b0,8'hC3,4'd7},  // R7
    {1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,8'h00,8'h11,1'b0,8'hC3,4'd4},  // R4
    {1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,8'h00,8'h00,1'b0,8'hC3,4'd11}, // R11
    {1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,8'h80,8'h00,1'b1,8'h80,4'd1},  // R1
    {1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,8'h00,8'h00,1'b0,8'h80,4'd3},  // R3
    {1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,8'h00,8'h00,1'b0,8'h80,4'd2}   // R2
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cpu_addr = '0;
  logic       cpu_wr = 1'b0;
  logic       cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       dbg_fuse = 1'b0;
  logic       dbg_grant = 1'b0;
  logic       dbg_rd = 1'b0;
  logic [7:0] dbg_data;
  logic       dbg_status;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dbgmb_top uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .dbg_fuse(dbg_fuse),
    .dbg_grant(dbg_grant), .dbg_rd(dbg_rd), .dbg_data(dbg_data), .dbg_status(dbg_status)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    cpu_wr = 1'b0; cpu_rd = 1'b0; dbg_rd = 1'b0; cpu_wdata = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R5: reset state
    check("R5", "flag after reset", {7'd0, dbg_status}, 8'h00);
    check("R5", "data after reset", dbg_data, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cpu_wr    = VEC[i][34];
      cpu_rd    = VEC[i][33];
      dbg_rd    = VEC[i][32];
      dbg_fuse  = VEC[i][31];
      dbg_grant = VEC[i][30];
      cpu_addr  = VEC[i][29] ? SHARED_A : EMPTY_A;
      cpu_wdata = VEC[i][28:21];
      #1;
      check($sformatf("R%0d", VEC[i][3:0]), $sformatf("rdata v%0d", i), cpu_rdata, VEC[i][20:13]);
      @(posedge clk);
      #1;
      idle();
      check($sformatf("R%0d", VEC[i][3:0]), $sformatf("flag v%0d", i), {7'd0, dbg_status}, {7'd0, VEC[i][12]});
      check($sformatf("R%0d", VEC[i][3:0]), $sformatf("dbg data v%0d", i), dbg_data, VEC[i][11:4]);
    end

    // R10: status pin tracks the flag seen by the processor in bit 7
    @(negedge clk);
    dbg_fuse = 1'b1; dbg_grant = 1'b1; cpu_addr = SHARED_A;
    cpu_wr = 1'b1; cpu_wdata = 8'h7E;
    @(negedge clk);
    idle(); cpu_rd = 1'b1;
    #1;
    check("R10", "status vs bit7", {7'd0, dbg_status}, {7'd0, cpu_rdata[7]});
    check("R2", "rdata 7E flagged", cpu_rdata, 8'hFE);

    // R9: repeated processor reads keep the flag
    repeat (3) @(negedge clk);
    #1;
    check("R9", "flag after reads", {7'd0, dbg_status}, 8'h01);

    // R5: reset in mid-run clears slot and ordinary register
    @(negedge clk);
    idle(); dbg_fuse = 1'b0; cpu_wr = 1'b1; cpu_wdata = 8'h99;
    @(negedge clk);
    idle(); rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R5", "flag after mid reset", {7'd0, dbg_status}, 8'h00);
    check("R5", "data after mid reset", dbg_data, 8'h00);
    cpu_rd = 1'b1;
    #1;
    check("R5", "ordinary reg after reset", cpu_rdata, 8'h00);
    @(negedge clk);
    idle();

    done = 1'b1;
    finish_run();
  end

endmodule